// File: doc/BRIEF.md
# Receive Error Tally Counters

This block keeps three wrapping tallies of failed receive frames for an Ethernet receiver: frames with a bad frame check sequence, frames that ended off an octet boundary, and frames the receiver threw away for lack of buffer space or because data arrived faster than it could be stored. The receive path pulses a one-cycle end-of-frame strobe that carries five status flags. The block gives each frame to at most one tally. It uses a fixed order of exclusion, so a frame with several problems is counted only under the error that dominates.

Software presets any tally through a small write port and reads it back through a select-driven read port. Presets are taken only while the channel is switched off. This lets software clear or seed the tallies before it starts reception.

Top module: `rx_err_stats`

## Requirements
- R1: After reset every tally reads zero. The read select codes are 0 for the check-sequence tally, 1 for the alignment tally and 2 for the discard tally. Code 3 always reads zero.
- R2: A preset (`sw_wr` high, `sw_sel` giving the tally with the same codes as R1) loads `sw_data` into that tally on the next clock, but only while `chan_on` is low. While `chan_on` is high the preset has no effect.
- R3: No frame increments more than one tally.
- R4: A frame flagged out-of-buffers or overrun increments the discard tally by one, whatever its other flags are.
- R5: An address-rejected frame with neither discard condition changes no tally.
- R6: A frame that passes R4 and R5 and has dribble bits increments the alignment tally, even if its check sequence is also bad.
- R7: A frame whose only applicable flag is a bad check sequence increments the check-sequence tally.
- R8: A frame with no flags changes no tally, and no tally changes in a cycle without a strobe or an accepted preset.
- R9: Each tally is 32 bits wide and wraps from 0xFFFFFFFF to 0.
- R10: When an accepted preset and an increment hit the same tally in the same cycle, the preset value is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_on | input | 1 | Channel enabled; blocks presets while high |
| eof_stb | input | 1 | One-cycle end-of-frame strobe |
| fr_addr_rej | input | 1 | Frame not addressed to this station |
| fr_no_buf | input | 1 | Frame arrived with no receive buffer free |
| fr_overrun | input | 1 | Frame hit a receive overrun |
| fr_dribble | input | 1 | Frame ended with a partial octet |
| fr_crc_bad | input | 1 | Frame check sequence mismatch |
| sw_wr | input | 1 | Preset strobe |
| sw_sel | input | 2 | Preset target tally |
| sw_data | input | 32 | Preset value |
| rd_sel | input | 2 | Read select |
| rd_data | output | 32 | Selected tally value |

## Verification
On every clock the assertions confirm the following: at most one tally is bumped, a discard-class frame always advances the discard tally, an accepted preset lands exactly, and a tally stays put when nothing targets it. The bench alone can show that the exclusion order itself is right, because that depends on the mixed flag combinations it drives. The same applies to reads of all three tallies through the select port, wrap-around from an all-ones preset, and presets ignored while the channel is on.

// File: rtl/rx_err_stats_pkg.sv
package rx_err_stats_pkg;

   localparam int unsigned NUM_TALLY = 3;
   localparam int unsigned SEL_W     = 2;

   localparam logic [SEL_W-1:0] SEL_CRC  = 2'd0;
   localparam logic [SEL_W-1:0] SEL_ALGN = 2'd1;
   localparam logic [SEL_W-1:0] SEL_DISC = 2'd2;

   typedef struct packed {
      logic addr_rej;
      logic no_buf;
      logic overrun;
      logic dribble;
      logic crc_bad;
   } rx_flags_t;

endpackage

// File: rtl/rx_err_classify.sv
module rx_err_classify
   import rx_err_stats_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 eof_i,
   input  rx_flags_t            flags_i,
   output logic [NUM_TALLY-1:0] bump_o
);

   logic discard, skip;

   always_comb begin
      discard = flags_i.no_buf | flags_i.overrun;
      skip    = flags_i.addr_rej;
      bump_o  = '0;
      if (eof_i) begin
         if (discard)               bump_o[SEL_DISC] = 1'b1;
         else if (skip)             bump_o           = '0;
         else if (flags_i.dribble)  bump_o[SEL_ALGN] = 1'b1;
         else if (flags_i.crc_bad)  bump_o[SEL_CRC]  = 1'b1;
      end
   end

   AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bump_o)); // R3
   AST_QUIET_NO_EOF: assert property (@(posedge clk) disable iff (!rst_n)
      !eof_i |-> (bump_o == '0)); // R8

endmodule

// File: rtl/rx_err_counter.sv
module rx_err_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic [CNT_W-1:0] cnt_o
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_o <= '0;
      else if (load_i) cnt_o <= load_val_i;
      else if (inc_i)  cnt_o <= cnt_o + ONE;
   end

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_o == $past(load_val_i))); // R10
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !load_i) |=> (cnt_o == $past(cnt_o) + ONE)); // R9
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !load_i) |=> $stable(cnt_o)); // R8

endmodule

// File: rtl/rx_err_stats.sv
module rx_err_stats
   import rx_err_stats_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter bit          RD_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_on,
   input  logic             eof_stb,
   input  logic             fr_addr_rej,
   input  logic             fr_no_buf,
   input  logic             fr_overrun,
   input  logic             fr_dribble,
   input  logic             fr_crc_bad,
   input  logic             sw_wr,
   input  logic [1:0]       sw_sel,
   input  logic [CNT_W-1:0] sw_data,
   input  logic [1:0]       rd_sel,
   output logic [CNT_W-1:0] rd_data
);

   if (CNT_W < 2) begin : g_bad_width
      $error("rx_err_stats: CNT_W must be at least 2");
   end

   rx_flags_t            flags;
   logic [NUM_TALLY-1:0] bump;
   logic [NUM_TALLY-1:0] load;
   logic [CNT_W-1:0]     tally [NUM_TALLY];
   logic [CNT_W-1:0]     rd_mux;
   logic                 wr_ok;

   assign flags = '{addr_rej: fr_addr_rej, no_buf: fr_no_buf,
                    overrun: fr_overrun, dribble: fr_dribble,
                    crc_bad: fr_crc_bad};
   assign wr_ok = sw_wr & ~chan_on;

   rx_err_classify u_classify (
      .clk     (clk),
      .rst_n   (rst_n),
      .eof_i   (eof_stb),
      .flags_i (flags),
      .bump_o  (bump)
   );

   for (genvar i = 0; i < NUM_TALLY; i++) begin : g_tally
      assign load[i] = wr_ok && (sw_sel == SEL_W'(i));
      rx_err_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk        (clk),
         .rst_n      (rst_n),
         .inc_i      (bump[i]),
         .load_i     (load[i]),
         .load_val_i (sw_data),
         .cnt_o      (tally[i])
      );
   end

   always_comb begin
      case (rd_sel)
         SEL_CRC:  rd_mux = tally[SEL_CRC];
         SEL_ALGN: rd_mux = tally[SEL_ALGN];
         SEL_DISC: rd_mux = tally[SEL_DISC];
         default:  rd_mux = '0;
      endcase
   end

   if (RD_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_data <= '0;
         else        rd_data <= rd_mux;
      end
   end else begin : g_rd_comb
      assign rd_data = rd_mux;
   end

   AST_DISC_BUMP: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_stb && (fr_no_buf || fr_overrun) && !load[SEL_DISC])
      |=> (tally[SEL_DISC] == $past(tally[SEL_DISC]) + 1'b1)); // R4
   AST_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_on && !eof_stb) |=> ($stable(tally[0]) && $stable(tally[1])
                                 && $stable(tally[2]))); // R2
   AST_REJ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_stb && fr_addr_rej && !fr_no_buf && !fr_overrun && !wr_ok)
      |=> ($stable(tally[0]) && $stable(tally[1]) && $stable(tally[2]))); // R5

endmodule

// File: tb/rx_err_stats_tb.sv
module rx_err_stats_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chan_on = 1'b0, eof_stb = 1'b0;
   logic        fr_addr_rej = 1'b0, fr_no_buf = 1'b0, fr_overrun = 1'b0;
   logic        fr_dribble = 1'b0, fr_crc_bad = 1'b0;
   logic        sw_wr = 1'b0;
   logic [1:0]  sw_sel = '0, rd_sel = '0;
   logic [31:0] sw_data = '0;
   logic [31:0] rd_data;

   int checks = 0, errors = 0, cycles = 0;
   logic [31:0] exp_t [3];

   always #10 clk = ~clk;

   rx_err_stats u_dut (.*);

   // expected winner: 0 crc, 1 align, 2 discard, 3 none
   function automatic int winner(logic a, logic nb, logic ov, logic dr, logic cb);
      if (nb || ov) return 2;
      if (a)        return 3;
      if (dr)       return 1;
      if (cb)       return 0;
      return 3;
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      for (int s = 0; s < 4; s++) begin
         rd_sel = 2'(s);
         #1;
         chk(rd_data, (s == 3) ? 32'd0 : exp_t[s], req);
      end
   endtask

   // one clock: optional frame and optional write, model updated
   task automatic step(input logic en, input logic eof, input logic [4:0] f,
                       input logic wr, input logic [1:0] ws, input logic [31:0] wd,
                       input string req);
      int w;
      @(negedge clk);
      chan_on = en; eof_stb = eof;
      {fr_addr_rej, fr_no_buf, fr_overrun, fr_dribble, fr_crc_bad} = f;
      sw_wr = wr; sw_sel = ws; sw_data = wd;
      w = eof ? winner(f[4], f[3], f[2], f[1], f[0]) : 3;
      if (w != 3) exp_t[w] = exp_t[w] + 32'd1;
      if (wr && !en && ws != 2'd3) exp_t[ws] = wd;
      @(posedge clk);
      #1;
      eof_stb = 1'b0; sw_wr = 1'b0;
      check_all(req);
   endtask

   initial begin
      while (cycles < 100000) begin
         @(posedge clk);
         cycles++;
      end
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      for (int i = 0; i < 3; i++) exp_t[i] = '0;
      repeat (3) @(posedge clk);
      #1;
      check_all("R1");
      @(negedge clk) rst_n = 1'b1;
      step(1, 0, 5'b0, 0, 0, 0, "R1");

      step(0, 0, 5'b0, 1, 2'd0, 32'h0000_0010, "R2");
      step(0, 0, 5'b0, 1, 2'd3, 32'h1234_5678, "R1");
      step(1, 0, 5'b0, 1, 2'd1, 32'hDEAD_BEEF, "R2");
      step(1, 1, 5'b01111, 0, 0, 0, "R4");
      step(1, 1, 5'b10100, 0, 0, 0, "R4");
      step(1, 1, 5'b10011, 0, 0, 0, "R5");
      step(1, 1, 5'b00011, 0, 0, 0, "R6");
      step(1, 1, 5'b00001, 0, 0, 0, "R7");
      step(1, 1, 5'b00000, 0, 0, 0, "R8");
      step(0, 0, 5'b0, 1, 2'd0, 32'hFFFF_FFFF, "R2");
      step(1, 1, 5'b00001, 0, 0, 0, "R9");
      step(0, 1, 5'b00010, 1, 2'd1, 32'h0000_0777, "R10");
      step(0, 1, 5'b01000, 1, 2'd2, 32'h0000_0005, "R10");
      step(0, 1, 5'b00001, 1, 2'd1, 32'h0000_0042, "R3");

      for (int n = 0; n < 400; n++) begin
         logic        en  = ($urandom % 4) != 0;
         logic        eof = ($urandom % 3) != 0;
         logic [4:0]  fl  = 5'($urandom);
         logic        wr  = ($urandom % 6) == 0;
         logic [1:0]  ws  = 2'($urandom);
         logic [31:0] wd  = ($urandom % 2) ? 32'hFFFF_FFFE + ($urandom % 2) : $urandom;
         step(en, eof, fl, wr, ws, wd, "R3");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule